// File: doc/BRIEF.md
# Slot-Packed Branch Address Sequencer

This block steps through the opcode slots of an 18-bit instruction word for a small word-addressed stack CPU. Each fetched word carries three full 5-bit opcodes and one short 3-bit opcode at the low end. The block issues a fetch for the word at the program pointer, latches it, and then presents one opcode per cycle. When the presented opcode is a branch, the bits to the right of its slot form the target address. How many target bits exist depends on the slot, so a branch placed late in a word can only move within a narrow range.

Branches placed first in a word can reach the whole 9-bit space, including register/port space, and also carry a mode bit. Branches placed second reach memory only. Branches placed third stay inside the current 8-word page. Calls hand out a 9-bit return pointer, and returns take a 9-bit pointer back. Every fetch address is decoded into RAM, ROM or register/port space, together with a cell index. The block does not execute any opcode itself.

Top module: `slot_branch_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the block requests a fetch at address 0. In that cycle opValid is low, opcode is 0 and extMode is low.
- R2: A fetch cycle is followed by execution cycles for slots 0, 1, 2 and 3 in turn, one cycle each. Slot k (k<3) presents word bits [17-5k -: 5]. Slot 3 presents {bits[2:0], 2'b00}.
- R3: A taken branch in slot 0 targets bits [8:0] of the word. The target may lie in register/port space. The same branch loads extMode from bit 9.
- R4: A taken branch in slot 1 targets {0, bits[7:0]}, so address bit 8 is always 0.
- R5: A taken branch in slot 2 targets {0, P[7:3], bits[2:0]}, where P is the address of the current word.
- R6: The fetch address is decoded as follows. Bit 8 set selects port. Otherwise bit 7 set selects ROM and bit 7 clear selects RAM. cellIdx is bits [5:0]. Exactly one select is high.
- R7: The block moves to the next word at P+1, wrapping from 511 to 0. This happens after slot 3, and after a conditional branch in slots 0 to 2 that is not taken, because the branch field fills the rest of that word.
- R8: extMode changes only through a taken non-return branch in slot 0. Branches in slots 1 and 2 leave it as it is.
- R9: A call (opcode 1) pulses pushReq with pushAddr = P+1, truncated to 9 bits. A return (opcode 0) jumps to retData[8:0] and ignores retData[17:9].
- R10: Opcodes 0, 1 and 2 (return, call, jump) are always taken and ignore branchTaken. Opcode 3 is taken only when branchTaken is high. A taken branch drops the rest of the word, shows its target on nextP and fetches the target next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrWord | input | 18 | Word read at fetchAddr, sampled during a fetch cycle |
| branchTaken | input | 1 | Decision for a conditional branch opcode |
| retData | input | 18 | Return-stack top; only bits [8:0] are used |
| fetchReq | output | 1 | High in the fetch cycle |
| fetchAddr | output | 9 | Current program pointer P |
| opValid | output | 1 | High when opcode holds a slot opcode |
| opcode | output | 5 | Opcode of the current slot |
| nextP | output | 9 | Value P takes at the next edge |
| pushReq | output | 1 | Call is pushing a return pointer |
| pushAddr | output | 9 | Return pointer P+1 |
| extMode | output | 1 | Extended-mode flag from slot-0 branches |
| selRam | output | 1 | Fetch address is in RAM |
| selRom | output | 1 | Fetch address is in ROM |
| selPort | output | 1 | Fetch address is in register/port space |
| cellIdx | output | 6 | Cell index within the region |

## Verification
The assertions check on every cycle that exactly one region select is high, that a fetch always leads into an execution cycle, and that P holds still during a fetch. They also check that a pushed return pointer is the current pointer plus one, and that extMode moves only in the cycle after an execution step. Target formation for each slot, page retention for slot 2, wrap-around of P, return-bit truncation and opcode ordering within a word can only be seen in the bench's program runs. The bench also sweeps all 512 addresses through slot-0 jumps to cover the region decode completely.

// File: rtl/slot_branch_pkg.sv
package slot_branch_pkg;
  localparam int WORD_BITS  = 18;
  localparam int OP_BITS    = 5;
  localparam int ADDR_BITS  = 9;
  localparam int SLOT_COUNT = 4;
  localparam int PAGE_BITS  = 3;
  localparam int CELL_BITS  = 6;

  localparam logic [OP_BITS-1:0] OP_RET  = 5'd0;
  localparam logic [OP_BITS-1:0] OP_CALL = 5'd1;
  localparam logic [OP_BITS-1:0] OP_JUMP = 5'd2;
  localparam logic [OP_BITS-1:0] OP_COND = 5'd3;

  typedef enum logic {PH_FETCH, PH_EXEC} phase_t;

  typedef struct packed {
    logic loadWord;
    logic takeBranch;
    logic useRet;
    logic seqNext;
    logic latchExt;
    logic pushRet;
  } seq_strobes_t;
endpackage

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_branch_pkg::*;
#(
  parameter int OP_W  = OP_BITS,
  parameter int SLOTS = SLOT_COUNT,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic              branchTaken,
  output seq_strobes_t      strobes,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              fetchReq,
  output logic              opValid
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  phase_t phase;
  logic isRet, isCall, isJump, isCond, isBranch, taken, seqStep;

  assign fetchReq = (phase == PH_FETCH);
  assign opValid  = (phase == PH_EXEC);

  always_comb begin
    isRet    = (opcode == OP_RET);
    isCall   = (opcode == OP_CALL);
    isJump   = (opcode == OP_JUMP);
    isCond   = (opcode == OP_COND);
    isBranch = isRet || isCall || isJump || isCond;
    taken    = opValid && (isRet || isCall || isJump || (isCond && branchTaken));
    // a branch field fills the rest of its word, so a branch not taken ends the word
    seqStep  = opValid && !taken && ((slotIdx == LAST_SLOT) || isBranch);

    strobes.loadWord   = fetchReq;
    strobes.takeBranch = taken;
    strobes.useRet     = taken && isRet;
    strobes.seqNext    = seqStep;
    strobes.latchExt   = taken && !isRet && (slotIdx == '0);
    strobes.pushRet    = opValid && isCall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_FETCH;
      slotIdx <= '0;
    end else if (phase == PH_FETCH) begin
      phase   <= PH_EXEC;
      slotIdx <= '0;
    end else if (taken || seqStep) begin
      phase   <= PH_FETCH;
      slotIdx <= '0;
    end else begin
      slotIdx <= slotIdx + 1'b1;
    end
  end
endmodule

// File: rtl/slot_seq_datapath.sv
module slot_seq_datapath
  import slot_branch_pkg::*;
#(
  parameter int WORD_W = WORD_BITS,
  parameter int OP_W   = OP_BITS,
  parameter int ADDR_W = ADDR_BITS,
  parameter int SLOTS  = SLOT_COUNT,
  parameter int PAGE_W = PAGE_BITS,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobes_t      strobes,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic              opValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [ADDR_W-1:0] retAddr,
  output logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] pReg,
  output logic [ADDR_W-1:0] nextP,
  output logic [ADDR_W-1:0] pushAddr,
  output logic              extMode
);
  localparam int TAIL_W = WORD_W - (SLOTS - 1) * OP_W;

  logic [WORD_W-1:0] wordReg;
  logic [OP_W-1:0]   slotOps [SLOTS];
  logic [ADDR_W-1:0] target, pInc;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < SLOTS - 1) begin : g_full
      assign slotOps[s] = wordReg[WORD_W-1-s*OP_W -: OP_W];
    end else begin : g_tail
      assign slotOps[s] = {wordReg[TAIL_W-1:0], {(OP_W-TAIL_W){1'b0}}};
    end
  end

  assign opcode   = opValid ? slotOps[slotIdx] : '0;
  assign pInc     = pReg + 1'b1;
  assign pushAddr = pInc;

  always_comb begin
    if (strobes.useRet) begin
      target = retAddr;
    end else begin
      case (slotIdx)
        SLOT_W'(0): target = wordReg[ADDR_W-1:0];
        SLOT_W'(1): target = {1'b0, wordReg[ADDR_W-2:0]};
        SLOT_W'(2): target = {1'b0, pReg[ADDR_W-2:PAGE_W], wordReg[PAGE_W-1:0]};
        default:    target = pReg;
      endcase
    end
  end

  always_comb begin
    if (strobes.takeBranch)   nextP = target;
    else if (strobes.seqNext) nextP = pInc;
    else                      nextP = pReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pReg    <= '0;
      wordReg <= '0;
      extMode <= 1'b0;
    end else begin
      pReg <= nextP;
      if (strobes.loadWord) wordReg <= instrWord;
      if (strobes.latchExt) extMode <= wordReg[ADDR_W];
    end
  end
endmodule

// File: rtl/slot_region_decode.sv
module slot_region_decode
  import slot_branch_pkg::*;
#(
  parameter int ADDR_W = ADDR_BITS,
  parameter int CELL_W = CELL_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              selRam,
  output logic              selRom,
  output logic              selPort,
  output logic [CELL_W-1:0] cellIdx
);
  logic unusedMidBits;
  assign unusedMidBits = ^addr[ADDR_W-3:CELL_W];

  assign selPort = addr[ADDR_W-1];
  assign selRom  = !addr[ADDR_W-1] && addr[ADDR_W-2];
  assign selRam  = !addr[ADDR_W-1] && !addr[ADDR_W-2];
  assign cellIdx = addr[CELL_W-1:0];
endmodule

// File: rtl/slot_branch_seq.sv
module slot_branch_seq
  import slot_branch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] instrWord,
  input  logic                 branchTaken,
  input  logic [WORD_BITS-1:0] retData,
  output logic                 fetchReq,
  output logic [ADDR_BITS-1:0] fetchAddr,
  output logic                 opValid,
  output logic [OP_BITS-1:0]   opcode,
  output logic [ADDR_BITS-1:0] nextP,
  output logic                 pushReq,
  output logic [ADDR_BITS-1:0] pushAddr,
  output logic                 extMode,
  output logic                 selRam,
  output logic                 selRom,
  output logic                 selPort,
  output logic [CELL_BITS-1:0] cellIdx
);
  localparam int SLOT_W = $clog2(SLOT_COUNT);

  seq_strobes_t      strobes;
  logic [SLOT_W-1:0] slotIdx;
  logic              unusedRetHigh;

  assign unusedRetHigh = ^retData[WORD_BITS-1:ADDR_BITS];
  assign pushReq       = strobes.pushRet;

  slot_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .branchTaken(branchTaken),
    .strobes(strobes), .slotIdx(slotIdx), .fetchReq(fetchReq), .opValid(opValid)
  );

  slot_seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .slotIdx(slotIdx), .opValid(opValid),
    .instrWord(instrWord), .retAddr(retData[ADDR_BITS-1:0]), .opcode(opcode),
    .pReg(fetchAddr), .nextP(nextP), .pushAddr(pushAddr), .extMode(extMode)
  );

  slot_region_decode u_region (
    .addr(fetchAddr), .selRam(selRam), .selRom(selRom), .selPort(selPort), .cellIdx(cellIdx)
  );
endmodule

// File: rtl/slot_branch_seq_checker.sv
module slot_branch_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       fetchReq,
  input logic [8:0] fetchAddr,
  input logic       opValid,
  input logic [8:0] nextP,
  input logic       pushReq,
  input logic [8:0] pushAddr,
  input logic       extMode,
  input logic       selRam,
  input logic       selRom,
  input logic       selPort
);
  p_fetch_then_exec_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> opValid);

  p_fetch_not_exec_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchReq && opValid));

  p_one_region_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({selRam, selRom, selPort}));

  p_hold_in_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> nextP == fetchAddr);

  p_push_next_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |-> pushAddr == 9'(fetchAddr + 9'd1));

  p_push_leaves_word_r10: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |=> fetchReq);

  p_ext_only_after_exec_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(extMode) |-> (fetchReq && $past(opValid)));
endmodule

bind slot_branch_seq slot_branch_seq_checker u_checker (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
  .opValid(opValid), .nextP(nextP), .pushReq(pushReq), .pushAddr(pushAddr),
  .extMode(extMode), .selRam(selRam), .selRom(selRom), .selPort(selPort)
);

// File: tb/test_slot_branch_seq.sv
module test_slot_branch_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] instrWord;
  logic        branchTaken = 1'b0;
  logic [17:0] retData = '0;
  logic        fetchReq, opValid, pushReq, extMode, selRam, selRom, selPort;
  logic [8:0]  fetchAddr, nextP, pushAddr;
  logic [4:0]  opcode;
  logic [5:0]  cellIdx;

  logic [17:0] mem [512];
  int totalChecks = 0;
  int failChecks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign instrWord = mem[fetchAddr];

  slot_branch_seq i_slot_branch_seq (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .branchTaken(branchTaken),
    .retData(retData), .fetchReq(fetchReq), .fetchAddr(fetchAddr), .opValid(opValid),
    .opcode(opcode), .nextP(nextP), .pushReq(pushReq), .pushAddr(pushAddr),
    .extMode(extMode), .selRam(selRam), .selRom(selRom), .selPort(selPort),
    .cellIdx(cellIdx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      failChecks++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int regionCode(input int a);
    if (a >= 256) return 4;
    if ((a % 256) >= 128) return 2;
    return 1;
  endfunction

  // fetch cycle: address, decode, optional extMode
  task automatic doFetch(input int addr, input int extExp, input string req);
    #1;
    chk(fetchReq && !opValid, {req, " fetch phase"}, {fetchReq, opValid}, 2);
    chk(fetchAddr == 9'(addr), {req, " fetch address"}, fetchAddr, addr);
    chk({selPort, selRom, selRam} == 3'(regionCode(addr)) && cellIdx == 6'(addr % 64),
        {req, " R6 region"}, {selPort, selRom, selRam, cellIdx}, (regionCode(addr) << 6) | (addr % 64));
    if (extExp >= 0) chk(extMode == 1'(extExp), {req, " R8 extMode"}, extMode, extExp);
    @(negedge clk);
  endtask

  task automatic doOp(input int op, input bit taken, input int expNext, input string req);
    branchTaken = taken;
    #1;
    chk(opValid && opcode == 5'(op), {req, " opcode"}, opcode, op);
    if (expNext >= 0) chk(nextP == 9'(expNext), {req, " nextP"}, nextP, expNext);
    @(negedge clk);
    branchTaken = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic int hop(input int a);
    return (a * 5 + 3) % 512;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      totalChecks++;
      failChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 512; a++) mem[a] = 18'h0;
    mem[9'h000] = {5'h10, 5'h11, 5'h12, 3'b101};
    mem[9'h001] = {5'h10, 5'd3, 8'h55};
    mem[9'h002] = {5'd2, 3'b000, 1'b1, 9'h1A5};
    mem[9'h1A5] = {5'h10, 5'h11, 5'd3, 3'b101};
    mem[9'h0A5] = {5'h13, 5'd2, 8'h43};
    mem[9'h043] = {5'd1, 3'b000, 1'b0, 9'h100};
    mem[9'h100] = {5'h17, 5'h18, 5'h19, 3'b000};
    mem[9'h044] = {5'd2, 3'b000, 1'b1, 9'h1FF};
    mem[9'h1FF] = {5'h14, 5'h15, 5'h16, 3'b110};

    doReset();
    #1;
    chk(opcode == 5'd0 && !opValid, "R1 reset opcode idle", {opValid, opcode}, 0);
    doFetch(0, 0, "R1 reset");
    // R2 slot order and slot-3 padding
    doOp(5'h10, 0, -1, "R2 slot0");
    doOp(5'h11, 0, -1, "R2 slot1");
    doOp(5'h12, 0, -1, "R2 slot2");
    doOp(5'h14, 0, 1, "R2 slot3 padded / R7 step");
    doFetch(1, 0, "R7 after slot3");
    // R7 conditional not taken in slot 1 ends the word
    doOp(5'h10, 0, -1, "R2 slot0");
    doOp(5'd3, 0, 2, "R7 cond not taken");
    doFetch(2, 0, "R7 skipped tail");
    // R3 slot0 jump into port space, branchTaken ignored (R10)
    doOp(5'd2, 0, 9'h1A5, "R3 R10 slot0 jump");
    doFetch(9'h1A5, 1, "R3 slot0 target with ext");
    // R5 slot2 page-relative, bit 8 cleared
    doOp(5'h10, 0, -1, "R2 slot0");
    doOp(5'h11, 0, -1, "R2 slot1");
    doOp(5'd3, 1, 9'h0A5, "R5 R10 slot2 cond taken");
    doFetch(9'h0A5, 1, "R5 R8 page target");
    // R4 slot1 jump, extMode unchanged
    doOp(5'h13, 0, -1, "R2 slot0");
    doOp(5'd2, 0, 9'h043, "R4 slot1 jump");
    doFetch(9'h043, 1, "R4 R8 slot1 target");
    // R9 call
    branchTaken = 1'b0;
    #1;
    chk(pushReq && pushAddr == 9'h044, "R9 call push", pushAddr, 9'h044);
    chk(nextP == 9'h100, "R9 call target", nextP, 9'h100);
    @(negedge clk);
    doFetch(9'h100, 0, "R3 R8 call clears ext");
    // R9 return from slot 3 with high bits ignored
    doOp(5'h17, 0, -1, "R2 slot0");
    doOp(5'h18, 0, -1, "R2 slot1");
    doOp(5'h19, 0, -1, "R2 slot2");
    retData = {9'h1FF, 9'h044};
    doOp(5'd0, 0, 9'h044, "R9 R10 return slot3");
    retData = '0;
    doFetch(9'h044, 0, "R9 return target");
    doOp(5'd2, 0, 9'h1FF, "R3 jump to top");
    doFetch(9'h1FF, 1, "R3 top address");
    doOp(5'h14, 0, -1, "R2 slot0");
    doOp(5'h15, 0, -1, "R2 slot1");
    doOp(5'h16, 0, -1, "R2 slot2");
    doOp(5'h18, 0, 0, "R7 wrap step");
    doFetch(0, 1, "R7 wrap to zero");

    // exhaustive sweep: slot-0 jumps through all 512 addresses
    for (int a = 0; a < 512; a++) mem[a] = {5'd2, 3'b000, 1'(a % 2), 9'(hop(a))};
    doReset();
    begin
      int cur = 0;
      doFetch(0, 0, "R1 sweep reset");
      for (int i = 0; i < 512; i++) begin
        doOp(5'd2, 0, hop(cur), "R3 sweep jump");
        doFetch(hop(cur), cur % 2, "R3 R6 sweep target");
        cur = hop(cur);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end
endmodule